// File: doc/BRIEF.md
# Clock Source Control Register

This block is the configuration register and start-up sequencer for the chip's internal clock. Software selects one of three clock sources and then sets an enable bit, both through a simple indexed register port. An external 48 MHz source is passed through almost at once. For either multiplier source, the block waits for a programmable number of reference cycles to stand in for multiplier lock, and only then lets the clock out.

Until the clock is valid, the output clock is held low by a glitch-free latch-based gate. Once the first enabling write has taken place, the source field is frozen until the next power-on reset. The enable bit can still be cleared and set again at any time. Two read-only status bits show whether the output clock is valid and whether any downstream module is still active. Software checks the module status before it turns the clock off.

Top module: `clock_source_reg`

## Requirements
- R1: After reset, a read of index 29h returns 0 while moduleActive is 0, and gatedClk stays low.
- R2: A write to index 29h sets bit 2 (enable) and bits 1:0 (source) in a single cycle, and the new values read back at once. The source codes are 00 = external 48 MHz, 01 = 14.318 MHz multiplier, 10 = 32.768 kHz multiplier and 11 = reserved. Reads of any other index return 0, and writes to any other index have no effect.
- R3: Once any write to index 29h has carried bit 2 = 1, bits 1:0 ignore every later write until reset. Bit 2 stays writable.
- R4: After power-on, the first 0-to-1 change of bit 2 with source 01 or 10 keeps bit 3 at 0 for FIRST_LOCK_CYCLES-1 rising edges after the write edge. Bit 3 reads 1 from the FIRST_LOCK_CYCLES-th edge.
- R5: Every later 0-to-1 change of bit 2 with a multiplier source uses RELOCK_CYCLES in place of FIRST_LOCK_CYCLES.
- R6: While bit 3 is 0, gatedClk is held low. While bit 3 is 1, gatedClk carries one pulse per refClk cycle.
- R7: With source 00, bit 3 reads 1 one edge after the enabling write, and the reference clock is passed through.
- R8: A write that clears bit 2 clears bit 3 at the write edge and freezes gatedClk low.
- R9: A write with bit 2 = 1 while bit 2 is already 1 neither restarts nor disturbs the lock count.
- R10: With source 11, setting bit 2 leaves bit 3 at 0 and gatedClk low indefinitely.
- R11: Bit 4 reads as the OR of moduleActive. Bits 3 and 4 ignore writes, and bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference input clock; also clocks the register port |
| rstN | input | 1 | Active-low power-on reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register index |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the addressed index (combinational) |
| moduleActive | input | NUM_MODULES | One bit per downstream module that is enabled |
| gatedClk | output | 1 | Gated output clock, held low until valid |

## Verification
If the lock counter is loaded or decremented wrongly, bit 3 rises on the wrong edge. The bench reads that bit on the exact edge where it should change, for both the first lock and a re-lock. A wrong state in the source lock flag shows up on the next rejected write as a changed source field. A stale valid flag or a wrong gate state shows up within ten reference cycles as pulses counted on gatedClk where none are expected, or missing pulses where they are expected.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  typedef enum logic [1:0] {
    SRC_EXT48 = 2'b00,
    SRC_MUL14 = 2'b01,
    SRC_MUL32 = 2'b10,
    SRC_RSVD  = 2'b11
  } srcSel_e;

  localparam int EN_BIT    = 2;
  localparam int VALID_BIT = 3;
  localparam int MOD_BIT   = 4;

  typedef struct packed {
    logic cfgWr;
    logic lockStart;
    logic lockStop;
  } strobes_t;
endpackage

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int FIRST_LOCK_CYCLES = 40,
  parameter int RELOCK_CYCLES     = 12,
  parameter logic [7:0] CFG_INDEX = 8'h29
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       enBit,
  input  srcSel_e    srcSel,
  input  logic       srcLocked,
  output strobes_t   strobes,
  output logic       clkValid
);
  localparam int MAX_CNT = (FIRST_LOCK_CYCLES > RELOCK_CYCLES) ? FIRST_LOCK_CYCLES : RELOCK_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             hitCfg;
  logic             newEn;
  srcSel_e          effSrc;
  logic             busy;
  logic             everLocked;
  logic [CNT_W-1:0] lockCnt;

  always_comb begin
    hitCfg            = regWrEn && (regAddr == CFG_INDEX);
    newEn             = regWrData[EN_BIT];
    effSrc            = srcLocked ? srcSel : srcSel_e'(regWrData[1:0]);
    strobes.cfgWr     = hitCfg;
    strobes.lockStart = hitCfg && newEn && !enBit && (effSrc != SRC_RSVD);
    strobes.lockStop  = hitCfg && !newEn && enBit;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      clkValid   <= 1'b0;
      everLocked <= 1'b0;
      lockCnt    <= '0;
    end else if (strobes.lockStop) begin
      busy     <= 1'b0;
      clkValid <= 1'b0;
    end else if (strobes.lockStart) begin
      busy     <= 1'b1;
      clkValid <= 1'b0;
      if (effSrc == SRC_EXT48)  lockCnt <= CNT_W'(1);
      else if (everLocked)      lockCnt <= CNT_W'(RELOCK_CYCLES);
      else                      lockCnt <= CNT_W'(FIRST_LOCK_CYCLES);
    end else if (busy) begin
      if (lockCnt == CNT_W'(1)) begin
        busy     <= 1'b0;
        clkValid <= 1'b1;
        if (srcSel != SRC_EXT48) everLocked <= 1'b1;
      end else begin
        lockCnt <= lockCnt - CNT_W'(1);
      end
    end
  end

  p_valid_needs_en_r8: assert property (@(posedge refClk) disable iff (!rstN)
    clkValid |-> enBit);
  p_start_clears_valid_r4: assert property (@(posedge refClk) disable iff (!rstN)
    strobes.lockStart |=> !clkValid);
  p_stop_clears_valid_r8: assert property (@(posedge refClk) disable iff (!rstN)
    strobes.lockStop |=> !clkValid);
  p_reserved_never_valid_r10: assert property (@(posedge refClk) disable iff (!rstN)
    (enBit && srcSel == SRC_RSVD) |-> !clkValid);
  p_no_restart_r9: assert property (@(posedge refClk) disable iff (!rstN)
    (clkValid && hitCfg && newEn) |=> clkValid);
endmodule

// File: rtl/clksrc_dp.sv
module clksrc_dp
  import clksrc_pkg::*;
#(
  parameter int NUM_MODULES       = 4,
  parameter logic [7:0] CFG_INDEX = 8'h29
) (
  input  logic                   refClk,
  input  logic                   rstN,
  input  logic [7:0]             regAddr,
  input  logic [7:0]             regWrData,
  input  strobes_t               strobes,
  input  logic                   clkValid,
  input  logic [NUM_MODULES-1:0] moduleActive,
  output logic                   enBit,
  output srcSel_e                srcSel,
  output logic                   srcLocked,
  output logic [7:0]             regRdData,
  output logic                   gatedClk
);
  logic moduleAny;
  logic gateOpen;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      srcSel    <= SRC_EXT48;
      srcLocked <= 1'b0;
    end else if (strobes.cfgWr) begin
      enBit <= regWrData[EN_BIT];
      if (!srcLocked)          srcSel    <= srcSel_e'(regWrData[1:0]);
      if (regWrData[EN_BIT])   srcLocked <= 1'b1;
    end
  end

  always_comb begin
    moduleAny = |moduleActive;
    regRdData = '0;
    if (regAddr == CFG_INDEX) begin
      regRdData[1:0]       = srcSel;
      regRdData[EN_BIT]    = enBit;
      regRdData[VALID_BIT] = clkValid;
      regRdData[MOD_BIT]   = moduleAny;
    end
  end

  always_latch begin
    if (!refClk) gateOpen = clkValid;
  end

  assign gatedClk = refClk & gateOpen;

  p_src_hold_r3: assert property (@(posedge refClk) disable iff (!rstN)
    srcLocked |=> $stable(srcSel));
  p_lock_on_enable_r3: assert property (@(posedge refClk) disable iff (!rstN)
    enBit |-> srcLocked);
endmodule

// File: rtl/clock_source_reg.sv
module clock_source_reg
  import clksrc_pkg::*;
#(
  parameter int NUM_MODULES       = 4,
  parameter int FIRST_LOCK_CYCLES = 40,
  parameter int RELOCK_CYCLES     = 12,
  parameter logic [7:0] CFG_INDEX = 8'h29
) (
  input  logic                   refClk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [7:0]             regAddr,
  input  logic [7:0]             regWrData,
  output logic [7:0]             regRdData,
  input  logic [NUM_MODULES-1:0] moduleActive,
  output logic                   gatedClk
);
  strobes_t strobes;
  logic     clkValid;
  logic     enBit;
  srcSel_e  srcSel;
  logic     srcLocked;

  clksrc_ctrl #(
    .FIRST_LOCK_CYCLES(FIRST_LOCK_CYCLES),
    .RELOCK_CYCLES(RELOCK_CYCLES),
    .CFG_INDEX(CFG_INDEX)
  ) i_ctrl (
    .refClk(refClk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .enBit(enBit), .srcSel(srcSel),
    .srcLocked(srcLocked), .strobes(strobes), .clkValid(clkValid)
  );

  clksrc_dp #(
    .NUM_MODULES(NUM_MODULES),
    .CFG_INDEX(CFG_INDEX)
  ) i_dp (
    .refClk(refClk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .strobes(strobes), .clkValid(clkValid), .moduleActive(moduleActive),
    .enBit(enBit), .srcSel(srcSel), .srcLocked(srcLocked),
    .regRdData(regRdData), .gatedClk(gatedClk)
  );
endmodule

// File: tb/test_clock_source_reg.sv
`timescale 1ns/1ps
module test_clock_source_reg;
  localparam int NMOD  = 4;
  localparam int FIRST = 40;
  localparam int RELK  = 12;

  logic            refClk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWrEn = 1'b0;
  logic [7:0]      regAddr = 8'h29;
  logic [7:0]      regWrData = 8'h00;
  logic [7:0]      regRdData;
  logic [NMOD-1:0] moduleActive = '0;
  logic            gatedClk;

  int checks = 0;
  int fails  = 0;
  int gCnt   = 0;

  always #2.5 refClk = ~refClk;
  always @(posedge gatedClk) gCnt++;

  clock_source_reg #(.NUM_MODULES(NMOD), .FIRST_LOCK_CYCLES(FIRST), .RELOCK_CYCLES(RELK))
    i_clock_source_reg (
      .refClk(refClk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
      .regWrData(regWrData), .regRdData(regRdData), .moduleActive(moduleActive),
      .gatedClk(gatedClk));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge refClk) rstN = 1'b0;
    repeat (3) @(negedge refClk);
    rstN = 1'b1;
  endtask

  // called just after a negedge; consumes exactly one rising edge
  task automatic wr(logic [7:0] a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge refClk);
    regWrEn = 1'b0; regAddr = 8'h29;
  endtask

  task automatic pulses(string req, int exp);
    int start = gCnt;
    repeat (10) @(negedge refClk);
    check(req, gCnt - start, exp);
  endtask

  task automatic tReset();
    check("R1 reset read", regRdData, 8'h00);
    pulses("R1 reset clock low", 0);
  endtask

  task automatic tFields();
    wr(8'h28, 8'hFF);
    check("R2 other index write ignored", regRdData, 8'h00);
    regAddr = 8'h28; #0.1;
    check("R2 other index reads 0", regRdData, 8'h00);
    regAddr = 8'h29;
    wr(8'h29, 8'h02);
    check("R2 source written", regRdData, 8'h02);
    wr(8'h29, 8'h01);
    check("R3 source writable before enable", regRdData, 8'h01);
    wr(8'h29, 8'h02);
  endtask

  task automatic tFirstLock();
    int start;
    wr(8'h29, 8'h06);
    start = gCnt;
    repeat (FIRST - 1) @(negedge refClk);
    check("R4 not valid before first lock", regRdData, 8'h06);
    check("R6 frozen during lock", gCnt - start, 0);
    @(negedge refClk);
    check("R4 valid at first lock", regRdData, 8'h0E);
    @(negedge refClk);
    pulses("R6 toggles when valid", 10);
  endtask

  task automatic tLockedFields();
    wr(8'h29, 8'h1D);
    check("R3 source locked, R9 still valid, R11 status ro", regRdData, 8'h0E);
    moduleActive = 4'b0100; #0.1;
    check("R11 module status", regRdData, 8'h1E);
    moduleActive = '0; #0.1;
    check("R11 module status clear", regRdData, 8'h0E);
  endtask

  task automatic tDisable();
    wr(8'h29, 8'h01);
    check("R8 disable clears valid, R3 source kept", regRdData, 8'h02);
    @(negedge refClk);
    pulses("R8 clock frozen after disable", 0);
  endtask

  task automatic tRelock();
    wr(8'h29, 8'h04);
    repeat (2) @(negedge refClk);
    wr(8'h29, 8'h04);
    repeat (RELK - 4) @(negedge refClk);
    check("R5 R9 not valid before relock", regRdData, 8'h06);
    @(negedge refClk);
    check("R5 R9 valid at relock", regRdData, 8'h0E);
  endtask

  task automatic tExternal();
    doReset();
    wr(8'h29, 8'h04);
    check("R7 external not yet valid", regRdData, 8'h04);
    @(negedge refClk);
    check("R7 external valid next edge", regRdData, 8'h0C);
    @(negedge refClk);
    pulses("R7 external passthrough", 10);
  endtask

  task automatic tReserved();
    doReset();
    wr(8'h29, 8'h07);
    repeat (FIRST + 10) @(negedge refClk);
    check("R10 reserved never valid", regRdData, 8'h07);
    pulses("R10 reserved clock low", 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    @(negedge refClk);
    tReset();
    tFields();
    tFirstLock();
    tLockedFields();
    tDisable();
    tRelock();
    tExternal();
    tReserved();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule